// File: doc/BRIEF.md
# Stride-Indexed Ring State Reader

This block gives software read access to per-ring state that is held in small on-chip memories rather than in flip-flop registers. Several banks, each with one entry per ring (16 by default), are exposed as single read addresses on a simple CSR strobe interface. Which entry a bank read returns does not come from the bus address. It comes from a separately programmed index register that holds a start position and a stride.

Software writes the index register once, for example with position 0 and stride 1. Each later read of any bank address returns the entry at the current position, and the position then moves forward by the stride, wrapping at 256. A whole bank, or an interleaved walk over several banks, can then be dumped with back-to-back reads. Hardware fills the banks through a separate write port. CSR writes never reach the banks.

Top module: `ring_csr_reader`

## Requirements
- R1: After reset the position and stride are both 0, `csr_rvalid_o` is low and `csr_rdata_o` is zero.
- R2: A read of the index register (read address 0) returns the position in data bits 7:0 and the stride in bits 15:8, with all other bits zero. The read does not change the position.
- R3: A read of a bank address (address 1 + bank number) in cycle N returns that bank's entry at the current position on `csr_rdata_o`, with `csr_rvalid_o` high, in cycle N+1.
- R4: After each bank read, the position becomes position plus stride modulo 256. A stride of 0 leaves the position unchanged.
- R5: A bank read while the position is 16 or higher returns zero. The position still advances.
- R6: A write to the index register (write address 0) loads the position from `csr_wdata_i[7:0]` and the stride from `csr_wdata_i[15:8]`. Higher data bits are ignored. If a bank read happens in the same cycle, the write wins: the position takes the written value, and the read returns the entry at the position held before the write.
- R7: A read of any other address returns zero and does not change the position.
- R8: A CSR write to a bank address has no effect on bank contents.
- R9: A hardware write (`hw_we_i`) is visible to bank reads in the following cycle. A bank read in the same cycle as a hardware write to the same entry returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_waddr_i | input | 4 | CSR write address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_raddr_i | input | 4 | CSR read address |
| csr_rdata_o | output | 64 | Read data, one cycle after the strobe |
| csr_rvalid_o | output | 1 | Read data valid |
| hw_we_i | input | 1 | Hardware bank write enable |
| hw_bank_i | input | 2 | Bank selected for the hardware write |
| hw_entry_i | input | 4 | Entry selected for the hardware write |
| hw_wdata_i | input | 64 | Hardware write data |

## Verification
The hardest case to reach is a cycle in which an index-register write and a bank read land together, because the two effects pull the position in different directions. The bench drives both strobes on one edge, using separate read and write addresses. It checks that the returned data comes from the old position and then reads the index register to confirm that the written value survived. The same approach is used for a hardware write that collides with a read of the same entry. A zero stride keeps the position fixed, so the old and new contents can be read back to back. Wrap-around is reached by starting near 255 with a large stride, so one read jumps from an out-of-range position back into the valid entries.

// File: rtl/ring_rd_pkg.sv
package ring_rd_pkg;
  localparam int unsigned DEF_DATA_W    = 64;
  localparam int unsigned DEF_NUM_BANKS = 3;
  localparam int unsigned DEF_ENTRIES   = 16;
  localparam int unsigned DEF_IDX_W     = 8;
  localparam int unsigned DEF_ADDR_W    = 4;
  localparam int unsigned DEF_BANK_BASE = 1;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_INDEX = 2'd1,
    TGT_BANK  = 2'd2
  } rd_tgt_e;
endpackage

// File: rtl/ring_idx_reg.sv
module ring_idx_reg #(
  parameter int unsigned IDX_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*IDX_W-1:0] load_val_i,
  input  logic               adv_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [IDX_W-1:0]   inc_o
);
  logic [IDX_W-1:0] idx_q, inc_q;

  // load wins over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      inc_q <= '0;
    end else if (load_i) begin
      idx_q <= load_val_i[IDX_W-1:0];
      inc_q <= load_val_i[2*IDX_W-1:IDX_W];
    end else if (adv_i) begin
      idx_q <= idx_q + inc_q;
    end
  end

  assign idx_o = idx_q;
  assign inc_o = inc_q;
endmodule

// File: rtl/ring_bank_array.sv
module ring_bank_array #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned BSEL_W    = 2,
  parameter int unsigned ENT_W     = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [BSEL_W-1:0]               bank_i,
  input  logic [ENT_W-1:0]                entry_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [ENT_W-1:0]                rd_entry_i,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] rd_data_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [ENTRIES];
    logic              hit;

    assign hit = we_i && (bank_i == BSEL_W'(b)) &&
                 ({1'b0, entry_i} < (ENT_W+1)'(ENTRIES));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
      end else if (hit) begin
        mem_q[entry_i] <= wdata_i;
      end
    end

    assign rd_data_o[b] = mem_q[rd_entry_i];
  end
endmodule

// File: rtl/ring_rd_decode.sv
module ring_rd_decode
  import ring_rd_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BANK_BASE = 1
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [IDX_W-1:0]                 inc_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data_i,
  output rd_tgt_e                          tgt_o,
  output logic [DATA_W-1:0]                data_o
);
  logic              in_range;
  logic [DATA_W-1:0] bank_sel;

  assign in_range = {1'b0, idx_i} < (IDX_W+1)'(ENTRIES);

  always_comb begin
    tgt_o    = TGT_NONE;
    bank_sel = '0;
    if (addr_i == '0) tgt_o = TGT_INDEX;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == ADDR_W'(BANK_BASE + b)) begin
        tgt_o    = TGT_BANK;
        bank_sel = bank_data_i[b];
      end
    end
  end

  always_comb begin
    unique case (tgt_o)
      TGT_INDEX: data_o = {{(DATA_W-2*IDX_W){1'b0}}, inc_i, idx_i};
      TGT_BANK:  data_o = in_range ? bank_sel : '0;
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/ring_csr_reader.sv
module ring_csr_reader
  import ring_rd_pkg::*;
#(
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_BANKS = DEF_NUM_BANKS,
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned IDX_W     = DEF_IDX_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned BANK_BASE = DEF_BANK_BASE,
  localparam int unsigned ENT_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_wr_i,
  input  logic [ADDR_W-1:0] csr_waddr_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  input  logic              csr_rd_i,
  input  logic [ADDR_W-1:0] csr_raddr_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  output logic              csr_rvalid_o,
  input  logic              hw_we_i,
  input  logic [BSEL_W-1:0] hw_bank_i,
  input  logic [ENT_W-1:0]  hw_entry_i,
  input  logic [DATA_W-1:0] hw_wdata_i
);
  logic [IDX_W-1:0]                 idx_q, inc_q;
  logic                             idx_load, idx_adv;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
  rd_tgt_e                          rd_tgt;
  logic [DATA_W-1:0]                rd_data;
  logic [DATA_W-1:0]                rdata_q;
  logic                             rvalid_q;

  assign idx_load = csr_wr_i && (csr_waddr_i == '0);
  assign idx_adv  = csr_rd_i && (rd_tgt == TGT_BANK) && !idx_load;

  ring_idx_reg #(.IDX_W(IDX_W)) u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (idx_load),
    .load_val_i (csr_wdata_i[2*IDX_W-1:0]),
    .adv_i      (idx_adv),
    .idx_o      (idx_q),
    .inc_o      (inc_q)
  );

  ring_bank_array #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .ENTRIES(ENTRIES),
    .BSEL_W(BSEL_W), .ENT_W(ENT_W)
  ) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (hw_we_i),
    .bank_i     (hw_bank_i),
    .entry_i    (hw_entry_i),
    .wdata_i    (hw_wdata_i),
    .rd_entry_i (idx_q[ENT_W-1:0]),
    .rd_data_o  (bank_data)
  );

  ring_rd_decode #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .ENTRIES(ENTRIES),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)
  ) u_dec (
    .addr_i      (csr_raddr_i),
    .idx_i       (idx_q),
    .inc_i       (inc_q),
    .bank_data_i (bank_data),
    .tgt_o       (rd_tgt),
    .data_o      (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= csr_rd_i;
      rdata_q  <= csr_rd_i ? rd_data : '0;
    end
  end

  assign csr_rdata_o  = rdata_q;
  assign csr_rvalid_o = rvalid_q;
endmodule

// File: rtl/ring_csr_reader_chk.sv
module ring_csr_reader_chk #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BANK_BASE = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_wr_i,
  input logic [ADDR_W-1:0] csr_waddr_i,
  input logic [DATA_W-1:0] csr_wdata_i,
  input logic              csr_rd_i,
  input logic [ADDR_W-1:0] csr_raddr_i,
  input logic [DATA_W-1:0] csr_rdata_o,
  input logic              csr_rvalid_o,
  input logic [IDX_W-1:0]  idx_i,
  input logic [IDX_W-1:0]  inc_i
);
  logic bank_rd, idx_wr, idx_rd, other_rd, oob;

  assign bank_rd  = csr_rd_i && (int'(csr_raddr_i) >= BANK_BASE) &&
                    (int'(csr_raddr_i) < BANK_BASE + NUM_BANKS);
  assign idx_wr   = csr_wr_i && (csr_waddr_i == '0);
  assign idx_rd   = csr_rd_i && (csr_raddr_i == '0);
  assign other_rd = csr_rd_i && !bank_rd && !idx_rd;
  assign oob      = int'(idx_i) >= ENTRIES;

  a_r3_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rd_i |=> csr_rvalid_o);

  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_rd && !idx_wr) |=> idx_i == IDX_W'($past(idx_i) + $past(inc_i)));

  a_r5_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_rd && oob) |=> csr_rdata_o == '0);

  a_r6_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> (idx_i == $past(csr_wdata_i[IDX_W-1:0])) &&
               (inc_i == $past(csr_wdata_i[2*IDX_W-1:IDX_W])));

  a_r2_idx_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_rd && !idx_wr) |=> $stable(idx_i));

  a_r7_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (other_rd && !idx_wr) |=> (csr_rdata_o == '0) && $stable(idx_i));
endmodule

bind ring_csr_reader ring_csr_reader_chk #(
  .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .ENTRIES(ENTRIES),
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_wr_i     (csr_wr_i),
  .csr_waddr_i  (csr_waddr_i),
  .csr_wdata_i  (csr_wdata_i),
  .csr_rd_i     (csr_rd_i),
  .csr_raddr_i  (csr_raddr_i),
  .csr_rdata_o  (csr_rdata_o),
  .csr_rvalid_o (csr_rvalid_o),
  .idx_i        (idx_q),
  .inc_i        (inc_q)
);

// File: tb/ring_csr_reader_test.sv
module ring_csr_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0, csr_rd = 1'b0, hw_we = 1'b0;
  logic [3:0]  csr_waddr = '0, csr_raddr = '0, hw_entry = '0;
  logic [1:0]  hw_bank = '0;
  logic [63:0] csr_wdata = '0, hw_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_rvalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [63:0] model [NB][NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_csr_reader uut (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_wr_i(csr_wr), .csr_waddr_i(csr_waddr), .csr_wdata_i(csr_wdata),
    .csr_rd_i(csr_rd), .csr_raddr_i(csr_raddr),
    .csr_rdata_o(csr_rdata), .csr_rvalid_o(csr_rvalid),
    .hw_we_i(hw_we), .hw_bank_i(hw_bank), .hw_entry_i(hw_entry),
    .hw_wdata_i(hw_wdata)
  );

  function automatic logic [63:0] pat(int b, int e, int v);
    return {8'hC0 + 8'(b), 8'(e), 16'(v), 32'hBEEF_0000 | 32'(e * 3 + b)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_rd = 1'b1; csr_raddr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    d = csr_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_waddr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic set_idx(input int idx, input int inc);
    wr(4'd0, {48'h0, 8'(inc), 8'(idx)});
  endtask

  task automatic hw_put(input int b, input int e, input logic [63:0] v);
    @(negedge clk);
    hw_we = 1'b1; hw_bank = 2'(b); hw_entry = 4'(e); hw_wdata = v;
    @(negedge clk);
    hw_we = 1'b0;
    model[b][e] = v;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 rvalid", 64'(csr_rvalid), 64'd0);
    check("R1 rdata", csr_rdata, 64'd0);
    rd(4'd0, d);
    check("R1 index reg", d, 64'd0);
  endtask

  task automatic t_fill;
    for (int b = 0; b < NB; b++)
      for (int e = 0; e < NE; e++) hw_put(b, e, pat(b, e, 1));
  endtask

  task automatic t_dump;
    logic [63:0] d;
    set_idx(0, 1);
    for (int e = 0; e < NE; e++) begin
      @(negedge clk);
      csr_rd = 1'b1; csr_raddr = 4'd1;
      @(negedge clk);
      csr_rd = 1'b0;
      check("R3 rvalid", 64'(csr_rvalid), 64'd1);
      check("R3 dump bank0", csr_rdata, model[0][e]);
    end
    rd(4'd0, d);
    check("R2 index after dump", d, 64'h0110);
    rd(4'd0, d);
    check("R2 index read no advance", d, 64'h0110);
  endtask

  task automatic t_stride;
    logic [63:0] d;
    set_idx(3, 5);
    rd(4'd1, d); check("R4 stride bank0 idx3", d, model[0][3]);
    rd(4'd2, d); check("R4 stride bank1 idx8", d, model[1][8]);
    rd(4'd3, d); check("R4 stride bank2 idx13", d, model[2][13]);
    rd(4'd1, d); check("R5 idx18 zero", d, 64'd0);
    rd(4'd0, d); check("R5 still advances", d, 64'h0517);
    set_idx(250, 10);
    rd(4'd2, d); check("R5 idx250 zero", d, 64'd0);
    rd(4'd2, d); check("R4 wrap to idx4", d, model[1][4]);
    rd(4'd0, d); check("R4 wrapped index", d, 64'h0A0E);
  endtask

  task automatic t_unmapped;
    logic [63:0] d;
    rd(4'd15, d); check("R7 unmapped zero", d, 64'd0);
    rd(4'd4, d);  check("R7 unmapped addr4 zero", d, 64'd0);
    rd(4'd0, d);  check("R7 no advance", d, 64'h0A0E);
  endtask

  task automatic t_collide_idx;
    logic [63:0] d;
    set_idx(2, 3);
    @(negedge clk);
    csr_wr = 1'b1; csr_waddr = 4'd0; csr_wdata = 64'h0107;
    csr_rd = 1'b1; csr_raddr = 4'd2;
    @(negedge clk);
    csr_wr = 1'b0; csr_rd = 1'b0;
    check("R6 read uses old idx", csr_rdata, model[1][2]);
    rd(4'd0, d);
    check("R6 write wins", d, 64'h0107);
    wr(4'd0, 64'hFFFF_FFFF_FFFF_3412);
    rd(4'd0, d);
    check("R6 upper bits ignored", d, 64'h3412);
  endtask

  task automatic t_csr_bank_write;
    logic [63:0] d;
    wr(4'd1, 64'h1234_5678_9ABC_DEF0);
    set_idx(0, 0);
    rd(4'd1, d);
    check("R8 bank unchanged", d, model[0][0]);
  endtask

  task automatic t_hw_collide;
    logic [63:0] d, old_v, new_v;
    old_v = model[2][5];
    new_v = pat(2, 5, 9);
    set_idx(5, 0);
    @(negedge clk);
    hw_we = 1'b1; hw_bank = 2'd2; hw_entry = 4'd5; hw_wdata = new_v;
    csr_rd = 1'b1; csr_raddr = 4'd3;
    @(negedge clk);
    hw_we = 1'b0; csr_rd = 1'b0;
    model[2][5] = new_v;
    check("R9 same cycle old data", csr_rdata, old_v);
    rd(4'd3, d);
    check("R9 new data visible", d, new_v);
    rd(4'd0, d);
    check("R4 zero stride holds", d, 64'h0005);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_dump();
    t_stride();
    t_unmapped();
    t_collide_idx();
    t_csr_bank_write();
    t_hw_collide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule